// File: doc/BRIEF.md
# Bit-Serial First-Order Recursive Filter Section

This block is one section of a recursive low-pass filter working on bit-serial two's-complement samples. It computes y(n) = x(n) + 0.5·y(n-1). Each input sample arrives least-significant bit first on a single wire. A start strobe marks the first bit of every sample. The result leaves on another single wire in the same serial order, one clock after the matching input bit. The halving in the feedback path is not a multiplier. It comes from reading the stored previous result one bit position later than the current bit. The fed-back word is therefore one bit narrower than the result. Its top bit is repeated to sign-extend it, and its lowest bit is dropped. Dropping that bit is the truncation, and it adds no register to the loop.

A frame lasts W+1 clocks. The input word has W bits, and the extra clock carries the top bit of the (W+1)-bit result. Because of that extra bit the sum can never overflow. A mode input chooses between truncation and rounding of the fed-back value. In rounding mode the dropped bit is fed in as the adder's carry at the start of the frame. The output is already a sign-extended (W+1)-bit word, so the section can feed another section of the same shape directly.

Top module: `sfr_first_order`

## Requirements
- R1: During synchronous reset and on the first cycle after it, `out_bit` and `out_start` are 0. Reset clears the loop state so that y(-1) = 0, including when the reset comes in the middle of a run.
- R2: A frame is W+1 cycles long, with `in_start` high only on its first cycle (position 0). Input bit k of the W-bit two's-complement sample is taken at position k, for k = 0 to W-1. The value on `in_bit` at position W is ignored.
- R3: The result y(n) is a (W+1)-bit two's-complement word sent LSB first. Bit k appears on `out_bit` in the cycle after input position k. `out_start` is high exactly in the cycle after `in_start`.
- R4: When `round_en` is 0 in a frame's start cycle, that frame computes y(n) = x(n) + floor(y(n-1)/2).
- R5: When `round_en` is 1 in a frame's start cycle, that frame computes y(n) = x(n) + floor((y(n-1)+1)/2).
- R6: The result never overflows (W+1 bits). A run of the most negative input reaches exactly -2^W, and the word 2^W-1 never appears.
- R7: Until the first `in_start` after reset, `out_bit` stays 0 whatever is driven on `in_bit`.
- R8: `round_en` is used only in the start cycle of a frame. Changing it at any other position has no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| round_en | input | 1 | 1 selects rounding of the fed-back half, 0 selects truncation; sampled in the start cycle |
| in_start | input | 1 | High in the first (LSB) cycle of each input frame |
| in_bit | input | 1 | Serial input sample, LSB first |
| out_start | output | 1 | High in the cycle that carries output bit 0 |
| out_bit | output | 1 | Serial (W+1)-bit result, LSB first |

## Verification
The recursion is driven with the following patterns:
- An all-zero run shows that no bias comes from the carry or the delay line.
- Long runs of the largest and the most negative sample drive the loop to its extreme values. These runs separate correct sign-extension of the fed-back word from a wrap. The negative run also shows whether truncation floors toward minus infinity.
- Alternating extremes and random samples exercise carries across every bit position. Junk driven at the extra position shows whether the input is sign-extended internally.
- The same random sequence repeated under rounding separates the carry-in at the frame start from plain truncation.
- Toggling the mode inside frames checks that it is sampled only at the start.
- A reset in the middle of the stream, followed by idle random input, checks that y(-1) returns to zero and that the output stays quiet.

// File: rtl/sfr_pkg.sv
package sfr_pkg;

    // Operands presented to the one-bit adder in a given cycle
    typedef struct packed {
        logic x;    // input sample bit (or held input sign)
        logic fb;   // fed-back half of the previous result
        logic cin;  // carry into this bit position
    } sfr_add_in_t;

    typedef struct packed {
        logic sum;
        logic cout;
    } sfr_add_out_t;

    function automatic sfr_add_out_t sfr_full_add(sfr_add_in_t a);
        sfr_add_out_t r;
        r.sum  = a.x ^ a.fb ^ a.cin;
        r.cout = (a.x & a.fb) | (a.x & a.cin) | (a.fb & a.cin);
        return r;
    endfunction

    // Width of a frame-position counter that can hold 0 .. w+1
    function automatic int sfr_pos_width(int w);
        return $clog2(w + 2);
    endfunction

endpackage

// File: rtl/sfr_frame_ctrl.sv
module sfr_frame_ctrl #(
    parameter int W = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic at_top_in,   // position W-1: last real input bit
    output logic at_ext,      // position W: extension bit
    output logic running      // at least one frame begun since reset
);
    localparam int PW = sfr_pkg::sfr_pos_width(W);
    localparam logic [PW-1:0] POS_TOP = PW'(W - 1);
    localparam logic [PW-1:0] POS_EXT = PW'(W);
    localparam logic [PW-1:0] POS_SAT = PW'(W + 1);

    logic [PW-1:0] pos_q;
    logic [PW-1:0] pos_now;
    logic          run_q;

    assign pos_now   = start ? '0 : pos_q;
    assign at_top_in = (pos_now == POS_TOP);
    assign at_ext    = (pos_now == POS_EXT) && run_q;
    assign running   = run_q | start;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q <= POS_SAT;
            run_q <= 1'b0;
        end else begin
            pos_q <= (pos_now == POS_SAT) ? POS_SAT : pos_now + 1'b1;
            run_q <= run_q | start;
        end
    end
endmodule

// File: rtl/sfr_serial_add.sv
module sfr_serial_add (
    input  logic clk,
    input  logic rst,
    input  logic enable,     // gates sum and carry before the first frame
    input  logic first,      // frame start: carry restarts here
    input  logic round_bit,  // carry-in used at the frame start
    input  logic x,
    input  logic fb,
    output logic sum
);
    import sfr_pkg::*;

    logic         carry_q;
    sfr_add_in_t  ain;
    sfr_add_out_t aout;

    always_comb begin
        ain.x   = x;
        ain.fb  = fb;
        ain.cin = first ? round_bit : carry_q;
        aout    = sfr_full_add(ain);
    end

    assign sum = enable & aout.sum;

    always_ff @(posedge clk) begin
        if (rst) carry_q <= 1'b0;
        else     carry_q <= enable & aout.cout;
    end
endmodule

// File: rtl/sfr_delay.sv
module sfr_delay #(
    parameter int DEPTH = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [DEPTH-1:0] stage_q;

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_stage
            if (i == 0) begin : g_head
                always_ff @(posedge clk) begin
                    if (rst) stage_q[0] <= 1'b0;
                    else     stage_q[0] <= d;
                end
            end else begin : g_body
                always_ff @(posedge clk) begin
                    if (rst) stage_q[i] <= 1'b0;
                    else     stage_q[i] <= stage_q[i-1];
                end
            end
        end
    endgenerate

    assign q = stage_q[DEPTH-1];
endmodule

// File: rtl/sfr_first_order.sv
module sfr_first_order #(
    parameter int W = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic round_en,
    input  logic in_start,
    input  logic in_bit,
    output logic out_start,
    output logic out_bit
);
    // Delay W brings bit k+1 of the previous (W+1)-cycle frame into position k
    localparam int LOOP_DEPTH = W;

    logic at_top_in, at_ext, running;
    logic xsign_q;   // held input sign for the extension position
    logic sign_q;    // sign of the previous result
    logic lsb_q;     // dropped LSB of the previous result, used for rounding
    logic dl_out;
    logic x_eff, fb_eff, sum;

    sfr_frame_ctrl #(.W(W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (in_start),
        .at_top_in (at_top_in),
        .at_ext    (at_ext),
        .running   (running)
    );

    // Input sign-extension and sign-extended halving of the fed-back word
    assign x_eff  = at_ext ? xsign_q : in_bit;
    assign fb_eff = at_ext ? sign_q  : dl_out;

    sfr_serial_add u_add (
        .clk       (clk),
        .rst       (rst),
        .enable    (running),
        .first     (in_start),
        .round_bit (round_en & lsb_q),
        .x         (x_eff),
        .fb        (fb_eff),
        .sum       (sum)
    );

    sfr_delay #(.DEPTH(LOOP_DEPTH)) u_loop (
        .clk (clk),
        .rst (rst),
        .d   (sum),
        .q   (dl_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            xsign_q   <= 1'b0;
            sign_q    <= 1'b0;
            lsb_q     <= 1'b0;
            out_bit   <= 1'b0;
            out_start <= 1'b0;
        end else begin
            if (at_top_in) xsign_q <= in_bit;
            if (at_ext)    sign_q  <= sum;
            if (in_start)  lsb_q   <= sum;
            out_bit   <= sum;
            out_start <= in_start;
        end
    end
endmodule

// File: rtl/sfr_first_order_chk.sv
module sfr_first_order_chk #(
    parameter int W = 8
) (
    input logic clk,
    input logic rst,
    input logic in_start,
    input logic out_start,
    input logic out_bit,
    input logic sign_q,
    input logic lsb_q
);
    localparam logic [W:0] MAX_WORD = {1'b0, {W{1'b1}}};

    logic         pv_q;
    logic [W-1:0] word_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pv_q   <= 1'b0;
            word_q <= '0;
        end else begin
            pv_q   <= 1'b1;
            word_q <= {out_bit, word_q[W-1:1]};
        end
    end

    // R3: output frame marker trails the input marker by one cycle
    p_out_start_lag_r3: assert property (@(posedge clk) disable iff (rst)
        pv_q |-> (out_start == $past(in_start)));

    // R4: stored sign used for extension equals the last bit sent out
    p_sign_latch_r4: assert property (@(posedge clk) disable iff (rst)
        in_start |-> (sign_q == out_bit));

    // R5: bit kept for rounding equals the result LSB sent out
    p_lsb_latch_r5: assert property (@(posedge clk) disable iff (rst)
        out_start |-> (lsb_q == out_bit));

    // R6: a completed output word never reaches the largest positive code
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
        in_start |-> ({out_bit, word_q} != MAX_WORD));
endmodule

bind sfr_first_order sfr_first_order_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_start  (in_start),
    .out_start (out_start),
    .out_bit   (out_bit),
    .sign_q    (sign_q),
    .lsb_q     (lsb_q)
);

// File: tb/test_sfr_first_order.sv
module test_sfr_first_order;
    localparam int W      = 8;
    localparam int PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic round_en = 1'b0;
    logic in_start = 1'b0;
    logic in_bit   = 1'b0;
    logic out_start, out_bit;

    int checks = 0;
    int errors = 0;
    int y_prev = 0;
    bit done = 1'b0;

    // expectation for the cycle just driven, checked at the next negedge
    bit    pend_valid = 1'b0;
    bit    pend_bit   = 1'b0;
    bit    pend_start = 1'b0;
    string pend_req   = "";

    always #(PERIOD/2) clk = ~clk;

    sfr_first_order #(.W(W)) i_sfr_first_order (
        .clk       (clk),
        .rst       (rst),
        .round_en  (round_en),
        .in_start  (in_start),
        .in_bit    (in_bit),
        .out_start (out_start),
        .out_bit   (out_bit)
    );

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // One cycle: check the previous cycle's result, then drive this cycle
    task automatic tick(bit st, bit b, bit rnd, bit exp_bit, string req);
        @(negedge clk);
        if (pend_valid) begin
            check(pend_req, "out_bit", int'(out_bit), int'(pend_bit));
            check("R3", "out_start", int'(out_start), int'(pend_start));
        end
        in_start   = st;
        in_bit     = b;
        round_en   = rnd;
        pend_valid = 1'b1;
        pend_bit   = exp_bit;
        pend_start = st;
        pend_req   = req;
    endtask

    // One frame; chaos toggles round_en away from the start cycle (R8)
    task automatic frame(int x, bit rnd, bit chaos, string req);
        int y;
        y = x + ((y_prev + (rnd ? 1 : 0)) >>> 1);
        for (int k = 0; k <= W; k++) begin
            bit b;
            bit r;
            b = (k < W) ? x[k] : 1'($urandom_range(0, 1));
            r = (k == 0) ? rnd : (chaos ? 1'($urandom_range(0, 1)) : rnd);
            tick(k == 0, b, r, y[k], req);
        end
        y_prev = y;
    endtask

    task automatic idle(int n, string req);
        for (int i = 0; i < n; i++)
            tick(1'b0, 1'($urandom_range(0, 1)), 1'b0, 1'b0, req);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_start = 1'b0; in_bit = 1'b0;
        pend_valid = 1'b0;
        y_prev = 0;
        repeat (3) @(negedge clk);
        // R1: outputs quiet while in reset
        check("R1", "out_bit in reset", int'(out_bit), 0);
        check("R1", "out_start in reset", int'(out_start), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "out_bit after reset", int'(out_bit), 0);
        check("R1", "out_start after reset", int'(out_start), 0);
    endtask

    function automatic int rand_x();
        return $signed($urandom_range(0, (1 << W) - 1)) - (1 << (W - 1));
    endfunction

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int xs[60];
        do_reset();
        idle(7, "R7");                                   // quiet before first frame
        for (int i = 0; i < 3; i++) frame(0, 1'b0, 1'b0, "R4");
        for (int i = 0; i < 20; i++) frame((1 << (W-1)) - 1, 1'b0, 1'b0, "R6");
        for (int i = 0; i < 20; i++) frame(-(1 << (W-1)), 1'b0, 1'b0, "R6");
        // R6: most negative run settles at -2^W
        check("R6", "settled value", y_prev, -(1 << W));
        for (int i = 0; i < 10; i++)
            frame((i % 2) ? -(1 << (W-1)) : (1 << (W-1)) - 1, 1'b0, 1'b0, "R4");
        for (int i = 0; i < 60; i++) xs[i] = rand_x();
        for (int i = 0; i < 60; i++) frame(xs[i], 1'b0, 1'b0, "R2");
        for (int i = 0; i < 60; i++) frame(xs[i], 1'b1, 1'b0, "R5");
        for (int i = 0; i < 20; i++) frame((1 << (W-1)) - 1, 1'b1, 1'b0, "R6");
        for (int i = 0; i < 20; i++) frame(-(1 << (W-1)), 1'b1, 1'b0, "R5");
        for (int i = 0; i < 60; i++)
            frame(rand_x(), 1'($urandom_range(0, 1)), 1'b1, "R8");
        do_reset();                                      // mid-run reset
        idle(5, "R7");
        for (int i = 0; i < 30; i++) frame(rand_x(), 1'b0, 1'b0, "R1");
        idle(1, "R3");
        @(negedge clk);
        check(pend_req, "out_bit", int'(out_bit), int'(pend_bit));
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule